// File: doc/BRIEF.md
# Microcoded Accumulator Processor Core

This block is a compact processor built around one accumulator. Each 16-bit instruction word carries a 4-bit opcode and a 12-bit operand. The operand is a direct word address, or a jump target, or it is unused. The core does not decode instructions in random logic. A micro-program counter steps through a small microcode store, and every micro-word raises a named set of read and write strobes. These strobes move one value per cycle over a shared data bus and a shared address bus. The bus endpoints are the program counter, instruction register, accumulator, B operand register, ALU, flag register and the two I/O ports.

Program and data share a 4K x 16 memory inside the block. Software image loading uses a simple write port, which is driven while the core is held in reset. After reset is released the core fetches from address 0. It runs until it executes a halt, then it raises `halted` and stays frozen until the next reset.

Top module: `acc_ucode_cpu`

## Requirements
- R1: While `rst_n` is low at a clock edge, the program counter, micro-program counter, accumulator, B register, flags and `out_port` clear to zero and `halted` reads 0; after release, execution starts at address 0.
- R2: An instruction word is `{opcode[15:12], operand[11:0]}` with opcodes 0 NOP, 1 LDA, 2 STA, 3 ADD, 4 SUB, 5 IN, 6 OUT, 7 JMP, 8 JN, 9 HLT, A CMP, B JG, C JE, D JL; codes E and F behave as NOP.
- R3: Every instruction begins with a two-cycle fetch: memory at PC is written into the instruction register while PC increments, then the decoder's start address is written into the micro-program counter; NOP consists of the fetch alone.
- R4: LDA loads the addressed memory word into the accumulator; STA writes the accumulator into the addressed word.
- R5: ADD and SUB replace the accumulator with accumulator plus or minus the addressed word, modulo 2^16.
- R6: ADD, SUB and CMP latch four flags: N is bit 15 of the ALU result (the difference for CMP), and G, E, L give the unsigned comparison of the accumulator against the addressed word; CMP leaves the accumulator unchanged.
- R7: JMP loads PC with the operand; JN, JG, JE and JL load PC with the operand only when flag N, G, E or L respectively is set, and otherwise fall through to the next word.
- R8: IN copies `in_port` into the accumulator; OUT copies the accumulator onto `out_port`, which holds its value at all other times.
- R9: HLT raises `halted`, which then stays high with PC, accumulator and `out_port` frozen until reset.
- R10: Counted with the fetch, NOP and HLT (until `halted` rises) take 2 cycles, LDA, STA, IN, OUT, JMP and each conditional jump take 3 cycles, and ADD, SUB and CMP take 4 cycles; after the last micro-step the micro-program counter returns to the fetch step.
- R11: When `load_en` is high at a clock edge, `load_data` is written into memory word `load_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | Image load write enable |
| load_addr | input | 12 | Image load word address |
| load_data | input | 16 | Image load word data |
| in_port | input | 16 | Input port value read by IN |
| out_port | output | 16 | Output port register written by OUT |
| halted | output | 1 | High while the core sits in the halt micro-step |

## Verification
The bench sweeps pairs of operands that include zero, one, the sign boundary 0x7FFF/0x8000 and all-ones. The mix covers add carry-out, subtract borrow and equal operands. A compare that used signed order would send the 0x8000 and 0xFFFF cases down the wrong jump path. A sign flag taken from the wrong bit would make JN pick the wrong output. A CMP that wrote the accumulator would corrupt a later sum. Each run's cycle count up to `halted` is also checked. A micro-sequence with a missing or extra step, or a conditional jump that loads PC while its flag is clear, therefore shows up as a count mismatch even when the final output matches. After halt, `in_port` is changed to show that the frozen core ignores it.

// File: rtl/acc_cpu_pkg.sv
// Package: shared types and microcode addresses for the accumulator core.
// Assumes a 4-bit opcode field and a 5-bit micro-program counter.
package acc_cpu_pkg;

    localparam int OPC_W = 4;
    localparam int UPC_W = 5;

    typedef enum logic [1:0] {
        ALU_NOP = 2'd0,
        ALU_CMP = 2'd1,
        ALU_ADD = 2'd2,
        ALU_SUB = 2'd3
    } alu_op_e;

    // Flag index; value doubles as bit position in the flag register.
    typedef enum logic [1:0] {
        FL_N = 2'd0,
        FL_G = 2'd1,
        FL_E = 2'd2,
        FL_L = 2'd3
    } flag_sel_e;

    // One microcode word: a strobe per bus endpoint plus sequencing bits.
    typedef struct packed {
        logic      pc_rd;
        logic      pc_wr;
        logic      pc_inc;
        logic      ir_wr;
        logic      ir_rd;
        logic      dec_rd;
        logic      upc_wr;
        logic      mem_rd;
        logic      mem_wr;
        logic      acc_rd;
        logic      acc_wr;
        logic      b_wr;
        logic      alu_rd;
        logic      flag_wr;
        logic      flag_rd;
        logic      port_rd;
        logic      port_wr;
        logic      halt;
        logic      last;
        alu_op_e   alu_op;
        flag_sel_e fsel;
    } uword_t;

    // Microcode entry points; fetch occupies the lowest addresses.
    localparam logic [UPC_W-1:0] UA_FETCH  = 5'd0;
    localparam logic [UPC_W-1:0] UA_DECODE = 5'd1;
    localparam logic [UPC_W-1:0] UA_STA    = 5'd2;
    localparam logic [UPC_W-1:0] UA_IN     = 5'd3;
    localparam logic [UPC_W-1:0] UA_OUT    = 5'd4;
    localparam logic [UPC_W-1:0] UA_HLT    = 5'd5;
    localparam logic [UPC_W-1:0] UA_LDA    = 5'd6;
    localparam logic [UPC_W-1:0] UA_ADD    = 5'd7;
    localparam logic [UPC_W-1:0] UA_SUB    = 5'd9;
    localparam logic [UPC_W-1:0] UA_CMP    = 5'd11;
    localparam logic [UPC_W-1:0] UA_JN     = 5'd13;
    localparam logic [UPC_W-1:0] UA_JG     = 5'd14;
    localparam logic [UPC_W-1:0] UA_JMP    = 5'd15;
    localparam logic [UPC_W-1:0] UA_JE     = 5'd16;
    localparam logic [UPC_W-1:0] UA_JL     = 5'd17;

endpackage

// File: rtl/acc_cpu_decoder.sv
// Opcode decoder: maps a 4-bit opcode to its microcode entry address.
// Assumes unused opcodes should behave as NOP (entry = fetch step).
module acc_cpu_decoder
    import acc_cpu_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output logic [UPC_W-1:0] start
);

    // Purpose: table lookup of the micro-program entry point.
    always_comb begin
        case (opcode)
            4'h1:    start = UA_LDA;
            4'h2:    start = UA_STA;
            4'h3:    start = UA_ADD;
            4'h4:    start = UA_SUB;
            4'h5:    start = UA_IN;
            4'h6:    start = UA_OUT;
            4'h7:    start = UA_JMP;
            4'h8:    start = UA_JN;
            4'h9:    start = UA_HLT;
            4'hA:    start = UA_CMP;
            4'hB:    start = UA_JG;
            4'hC:    start = UA_JE;
            4'hD:    start = UA_JL;
            default: start = UA_FETCH;
        endcase
    end

endmodule

// File: rtl/acc_cpu_urom.sv
// Microcode store: returns the strobe word for the current micro-address.
// Assumes unused addresses should fall back to the fetch step.
module acc_cpu_urom
    import acc_cpu_pkg::*;
(
    input  logic [UPC_W-1:0] upc,
    output uword_t           uw
);

    // Purpose: combinational microcode contents, one case item per step.
    always_comb begin
        uw        = '0;
        uw.alu_op = ALU_NOP;
        uw.fsel   = FL_N;
        case (upc)
            UA_FETCH: begin
                uw.pc_rd  = 1'b1;
                uw.mem_rd = 1'b1;
                uw.ir_wr  = 1'b1;
                uw.pc_inc = 1'b1;
            end
            UA_DECODE: begin
                uw.ir_rd  = 1'b1;
                uw.dec_rd = 1'b1;
                uw.upc_wr = 1'b1;
            end
            UA_STA: begin
                uw.ir_rd  = 1'b1;
                uw.acc_rd = 1'b1;
                uw.mem_wr = 1'b1;
                uw.last   = 1'b1;
            end
            UA_IN: begin
                uw.port_rd = 1'b1;
                uw.acc_wr  = 1'b1;
                uw.last    = 1'b1;
            end
            UA_OUT: begin
                uw.acc_rd  = 1'b1;
                uw.port_wr = 1'b1;
                uw.last    = 1'b1;
            end
            UA_HLT: begin
                uw.halt = 1'b1;
            end
            UA_LDA: begin
                uw.ir_rd  = 1'b1;
                uw.mem_rd = 1'b1;
                uw.acc_wr = 1'b1;
                uw.last   = 1'b1;
            end
            UA_ADD, UA_SUB, UA_CMP: begin
                uw.ir_rd  = 1'b1;
                uw.mem_rd = 1'b1;
                uw.b_wr   = 1'b1;
            end
            UA_ADD + 5'd1: begin
                uw.alu_op  = ALU_ADD;
                uw.alu_rd  = 1'b1;
                uw.acc_wr  = 1'b1;
                uw.flag_wr = 1'b1;
                uw.last    = 1'b1;
            end
            UA_SUB + 5'd1: begin
                uw.alu_op  = ALU_SUB;
                uw.alu_rd  = 1'b1;
                uw.acc_wr  = 1'b1;
                uw.flag_wr = 1'b1;
                uw.last    = 1'b1;
            end
            UA_CMP + 5'd1: begin
                uw.alu_op  = ALU_CMP;
                uw.flag_wr = 1'b1;
                uw.last    = 1'b1;
            end
            UA_JMP: begin
                uw.ir_rd = 1'b1;
                uw.pc_wr = 1'b1;
                uw.last  = 1'b1;
            end
            UA_JN, UA_JG, UA_JE, UA_JL: begin
                uw.ir_rd   = 1'b1;
                uw.flag_rd = 1'b1;
                uw.last    = 1'b1;
                case (upc)
                    UA_JG:   uw.fsel = FL_G;
                    UA_JE:   uw.fsel = FL_E;
                    UA_JL:   uw.fsel = FL_L;
                    default: uw.fsel = FL_N;
                endcase
            end
            default: begin
                uw.last = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/acc_cpu_alu.sv
// ALU: adds or subtracts B from the accumulator and derives four flags.
// Assumes unsigned comparison for G/E/L; N is the result sign bit.
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  alu_op_e      op,
    output logic [W-1:0] res,
    output logic [3:0]   flags
);

    logic [W-1:0] sum;
    logic [W-1:0] diff;

    assign sum  = x + y;
    assign diff = x - y;

    // Purpose: select the result driven onto the data bus.
    always_comb begin
        case (op)
            ALU_ADD:          res = sum;
            ALU_SUB, ALU_CMP: res = diff;
            default:          res = x;
        endcase
    end

    // Purpose: pack flags in flag_sel_e bit order {L, E, G, N}.
    always_comb begin
        flags[FL_N] = res[W-1];
        flags[FL_G] = (x > y);
        flags[FL_E] = (x == y);
        flags[FL_L] = (x < y);
    end

endmodule

// File: rtl/acc_cpu_mem.sv
// Unified program/data memory: combinational read, synchronous write.
// Assumes one write per cycle; contents are not reset.
module acc_cpu_mem #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Purpose: store one word on a write strobe.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/acc_ucode_cpu.sv
// Top: accumulator processor sequenced by microcode over two shared buses.
// Assumes the image is loaded through load_* while rst_n is held low.
module acc_ucode_cpu
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data,
    input  logic [DATA_W-1:0] in_port,
    output logic [DATA_W-1:0] out_port,
    output logic              halted
);

    localparam int DEC_PAD = DATA_W - UPC_W;

    logic [UPC_W-1:0]  upc_q;
    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] ir_q;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] b_q;
    logic [3:0]        flags_q;
    logic [DATA_W-1:0] out_q;

    uword_t            uw;
    logic [UPC_W-1:0]  dec_start;
    logic [DATA_W-1:0] alu_res;
    logic [3:0]        alu_flags;
    logic [DATA_W-1:0] mem_rdata;
    logic [ADDR_W-1:0] abus;
    logic [DATA_W-1:0] dbus;
    logic              pc_load;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [DATA_W-1:0] mem_wdata;

    acc_cpu_urom u_urom (
        .upc (upc_q),
        .uw  (uw)
    );

    acc_cpu_decoder u_dec (
        .opcode (ir_q[DATA_W-1 -: OPC_W]),
        .start  (dec_start)
    );

    acc_cpu_alu #(.W(DATA_W)) u_alu (
        .x     (acc_q),
        .y     (b_q),
        .op    (uw.alu_op),
        .res   (alu_res),
        .flags (alu_flags)
    );

    acc_cpu_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (abus),
        .rdata (mem_rdata)
    );

    // Purpose: address bus source, PC or IR operand.
    always_comb begin
        if (uw.pc_rd)      abus = pc_q;
        else if (uw.ir_rd) abus = ir_q[ADDR_W-1:0];
        else               abus = '0;
    end

    // Purpose: data bus source, chosen by the single active read strobe.
    always_comb begin
        if (uw.mem_rd)       dbus = mem_rdata;
        else if (uw.acc_rd)  dbus = acc_q;
        else if (uw.alu_rd)  dbus = alu_res;
        else if (uw.dec_rd)  dbus = {{DEC_PAD{1'b0}}, dec_start};
        else if (uw.port_rd) dbus = in_port;
        else                 dbus = '0;
    end

    // Purpose: memory write mux, image loading takes priority over the core.
    always_comb begin
        mem_we    = load_en | uw.mem_wr;
        mem_waddr = load_en ? load_addr : abus;
        mem_wdata = load_en ? load_data : dbus;
    end

    assign pc_load = uw.pc_wr | (uw.flag_rd & flags_q[uw.fsel]);

    // Purpose: micro-program counter sequencing (dispatch, hold, return, step).
    always_ff @(posedge clk) begin
        if (!rst_n)          upc_q <= UA_FETCH;
        else if (uw.upc_wr)  upc_q <= dbus[UPC_W-1:0];
        else if (uw.halt)    upc_q <= upc_q;
        else if (uw.last)    upc_q <= UA_FETCH;
        else                 upc_q <= upc_q + 1'b1;
    end

    // Purpose: program counter load from address bus or increment.
    always_ff @(posedge clk) begin
        if (!rst_n)          pc_q <= '0;
        else if (pc_load)    pc_q <= abus;
        else if (uw.pc_inc)  pc_q <= pc_q + 1'b1;
    end

    // Purpose: datapath registers written from the data bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q  <= '0;
            acc_q <= '0;
            b_q   <= '0;
            out_q <= '0;
        end else begin
            if (uw.ir_wr)   ir_q  <= dbus;
            if (uw.acc_wr)  acc_q <= dbus;
            if (uw.b_wr)    b_q   <= dbus;
            if (uw.port_wr) out_q <= dbus;
        end
    end

    // Purpose: flag register latched on ALU steps.
    always_ff @(posedge clk) begin
        if (!rst_n)          flags_q <= '0;
        else if (uw.flag_wr) flags_q <= alu_flags;
    end

    assign out_port = out_q;
    assign halted   = uw.halt;

    AST_DBUS_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({uw.mem_rd, uw.acc_rd, uw.alu_rd, uw.dec_rd, uw.port_rd})); // R3

    AST_ABUS_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        !(uw.pc_rd && uw.ir_rd)); // R3

    AST_FETCH_ADVANCES_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (upc_q == UA_FETCH) |=> (pc_q == $past(pc_q) + 1'b1)); // R3

    AST_RETURN_TO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (uw.last && !uw.halt && !uw.upc_wr) |=> (upc_q == UA_FETCH)); // R10

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(pc_q) && $stable(acc_q) && $stable(out_port))); // R9

    AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !uw.port_wr |=> $stable(out_port)); // R8

    AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (uw.flag_wr && uw.alu_op == ALU_CMP) |=> $stable(acc_q)); // R6

    AST_JUMP_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (uw.flag_rd && !flags_q[uw.fsel]) |=> $stable(pc_q)); // R7

endmodule

// File: tb/acc_ucode_cpu_tb.sv
`timescale 1ns/1ps
// Bench: sweeps operand pairs through three small programs, checks results and cycle counts.
module acc_ucode_cpu_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic [11:0] load_addr = '0;
    logic [15:0] load_data = '0;
    logic [15:0] in_port = '0;
    logic [15:0] out_port;
    logic        halted;

    int vectors = 0;
    int errors  = 0;
    int wd      = 0;
    bit done    = 1'b0;

    acc_ucode_cpu u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_addr (load_addr),
        .load_data (load_data),
        .in_port   (in_port),
        .out_port  (out_port),
        .halted    (halted)
    );

    always #2.5 clk = ~clk;

    function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] a);
        return {op, a};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R11: image load through the write port while reset is held.
    task automatic ld(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        load_en   = 1'b1;
        load_addr = a;
        load_data = d;
        @(negedge clk);
        load_en   = 1'b0;
    endtask

    // Release reset, count edges until halted, check output, halt hold, reset.
    task automatic run(input logic [15:0] exp_out, input int exp_cyc, input string tag);
        int n;
        logic [15:0] held;
        @(negedge clk);
        rst_n = 1'b1;
        n = 0;
        while (!halted && n < 500) begin
            @(posedge clk);
            #1;
            n++;
        end
        chk(out_port == exp_out, {tag, " result"}, 32'(out_port), 32'(exp_out));
        chk(n == exp_cyc, "R10 cycle count", 32'(n), 32'(exp_cyc));
        held = out_port;
        in_port = ~in_port;
        repeat (4) @(posedge clk);
        #1;
        chk(halted && out_port == held, "R9 halt holds", {15'd0, halted, out_port}, {15'd0, 1'b1, held});
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk(out_port == 16'h0 && !halted, "R1 reset clears", {15'd0, halted, out_port}, 32'h0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 150000 && !done) begin
                done = 1'b1;
                errors++;
                vectors++;
                $display("FAIL watchdog actual=%0d expected<150000", wd);
                $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [15:0] vals [8];
        vals = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234, 16'h00FF};

        repeat (3) @(posedge clk);
        #1;
        chk(out_port == 16'h0 && !halted, "R1 reset state", {15'd0, halted, out_port}, 32'h0);

        // R3 R9: a lone HLT at address 0 halts after its 2-cycle fetch.
        ld(12'h000, ins(4'h9, 12'h000));
        run(16'h0000, 2, "R9 lone HLT");

        foreach (vals[i]) begin
            foreach (vals[j]) begin
                logic [15:0] a, b, d, s, xin, exp_c;
                int cyc_c;
                a = vals[i];
                b = vals[j];
                s = a + b;
                d = a - b;

                // R2 R3 R4 R5 R6: NOP, opcode E as NOP, CMP keeps acc, ADD, STA/LDA round trip.
                ld(12'h000, ins(4'h0, 12'h000));
                ld(12'h001, ins(4'hE, 12'h123));
                ld(12'h002, ins(4'h1, 12'h100));
                ld(12'h003, ins(4'hA, 12'h101));
                ld(12'h004, ins(4'h3, 12'h101));
                ld(12'h005, ins(4'h2, 12'h102));
                ld(12'h006, ins(4'h1, 12'h103));
                ld(12'h007, ins(4'h1, 12'h102));
                ld(12'h008, ins(4'h6, 12'h000));
                ld(12'h009, ins(4'h9, 12'h000));
                ld(12'h100, a);
                ld(12'h101, b);
                ld(12'h102, 16'hDEAD);
                ld(12'h103, 16'h0F0F);
                run(s, 29, "R5 ADD/R4 STA");

                // R5 R7 R8: SUB, then JN picks IN or falls through.
                xin = 16'h5A5A ^ a;
                in_port = xin;
                ld(12'h000, ins(4'h1, 12'h100));
                ld(12'h001, ins(4'h4, 12'h101));
                ld(12'h002, ins(4'h6, 12'h000));
                ld(12'h003, ins(4'h8, 12'h005));
                ld(12'h004, ins(4'h9, 12'h000));
                ld(12'h005, ins(4'h5, 12'h000));
                ld(12'h006, ins(4'h6, 12'h000));
                ld(12'h007, ins(4'h9, 12'h000));
                ld(12'h100, a);
                ld(12'h101, b);
                in_port = xin;
                if (d[15]) run(xin, 21, "R7 JN taken/R8 IN");
                else       run(d, 15, "R5 SUB/R7 JN not taken");

                // R6 R7: unsigned compare drives JG/JE/JL, JMP joins paths.
                ld(12'h000, ins(4'h1, 12'h100));
                ld(12'h001, ins(4'hA, 12'h101));
                ld(12'h002, ins(4'hB, 12'h006));
                ld(12'h003, ins(4'hC, 12'h008));
                ld(12'h004, ins(4'hD, 12'h00A));
                ld(12'h005, ins(4'h9, 12'h000));
                ld(12'h006, ins(4'h1, 12'h102));
                ld(12'h007, ins(4'h7, 12'h00B));
                ld(12'h008, ins(4'h1, 12'h103));
                ld(12'h009, ins(4'h7, 12'h00B));
                ld(12'h00A, ins(4'h1, 12'h104));
                ld(12'h00B, ins(4'h6, 12'h000));
                ld(12'h00C, ins(4'h9, 12'h000));
                ld(12'h100, a);
                ld(12'h101, b);
                ld(12'h102, 16'd1);
                ld(12'h103, 16'd2);
                ld(12'h104, 16'd3);
                if (a > b) begin
                    exp_c = 16'd1;
                    cyc_c = 21;
                end else if (a == b) begin
                    exp_c = 16'd2;
                    cyc_c = 24;
                end else begin
                    exp_c = 16'd3;
                    cyc_c = 24;
                end
                run(exp_c, cyc_c, "R6 compare flags/R7 JG JE JL");
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule